// File: doc/BRIEF.md
# L1 Line Write-Permission Controller with Atomic Non-Migration

This block is the per-line state controller sitting on the processor side of an L1 data cache in a token-style MOESI protocol. It turns processor requests (load, instruction fetch, store, atomic) into coherence events. It tracks the stable states NP, I, S, O, M and MM, the write-window states M_W and MM_W, and the transient states IS, IM, SM and OM. On a miss it issues a read or write request. It keeps one tracking entry for the outstanding miss, and that entry records whether the miss was caused by an atomic. Requests that arrive while the line is transient are bounced back for a later retry.

Its purpose is to keep lines touched by atomics out of migratory ownership. With suppression enabled, an atomic settles the line in the non-migratory M state instead of MM. A later read from another core can then take only read permission, and a pending store-conditional keeps its chance to succeed. With suppression disabled, an atomic is handled exactly like a store. The use timer that closes a write window is external. Its expiry comes in on a timeout input together with a flag that says whether a starving requester holds a lock. Token counting, persistent-request arbitration and data storage are outside this block.

Top module: `l1_wperm_ctrl`

## Requirements
- R1: After reset the line state is NP (code 0), no tracking entry is held, and with all inputs low every pulse output is low. State codes on `line_state`: NP=0, I=1, S=2, O=3, M=4, MM=5, M_W=6, MM_W=7, IS=8, IM=9, SM=10, OM=11.
- R2: When `cfg_no_mig` is 0, an atomic request (`req_kind`=3) behaves exactly as a store (`req_kind`=2) in every state. For example, in MM it hits and the line stays in MM.
- R3: A store or atomic request moves NP or I to IM, S to SM and O to OM. It pulses `wr_req` for one cycle and allocates the tracking entry, whose atomic flag is set exactly when `req_kind` was 3.
- R4: A load (`req_kind`=0) or ifetch (`req_kind`=1) in NP or I moves the line to IS, pulses `rd_req` and allocates the entry with its atomic flag clear. A fill resolves IS according to `fill_kind`: 0 gives S and 1 gives O, and in both cases the entry is freed; 2 or 3 gives M_W and the entry is kept. A fill resolves IM, SM or OM to MM_W and keeps the entry. A fill in any other state is ignored.
- R5: In a transient state (IS, IM, SM, OM) any request pulses `retry`, and the state and the entry stay unchanged.
- R6: In MM a store hits and the line stays in MM. With `cfg_no_mig` at 1, an atomic hits and the line moves to M.
- R7: A store hit in M moves the line to MM. An atomic hit in M with suppression leaves the line in M. In M_W a store hits and moves the line to MM_W, while an atomic with suppression hits and stays in M_W. In MM_W both hit and the line stays in MM_W.
- R8: A load or ifetch in S, O, M, MM, M_W or MM_W produces a one-cycle `hit` pulse and changes no state.
- R9: A timeout with `tmo_starver` low ends the write window and frees the entry. M_W goes to M. MM_W goes to M when `cfg_no_mig` is 1 and the entry's atomic flag is set, and to MM otherwise.
- R10: A timeout with `tmo_starver` high in M_W or MM_W pulses `starve` and leaves the state and the entry unchanged.
- R11: A timeout outside M_W and MM_W is ignored. An invalidation moves S, O, M or MM to I and is ignored in every other state.
- R12: When several events arrive in one cycle, only the highest-priority one acts, in the order timeout, fill, invalidation, request. A request that is not accepted pulses `retry`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_no_mig | input | 1 | 1 = keep atomic-touched lines non-migratory |
| req_valid | input | 1 | Processor request present |
| req_kind | input | 2 | 0 load, 1 ifetch, 2 store, 3 atomic |
| fill_valid | input | 1 | Outstanding miss completes |
| fill_kind | input | 2 | 0 shared, 1 owned, 2/3 exclusive (read misses only) |
| inv_valid | input | 1 | External invalidation of the line |
| tmo_valid | input | 1 | Use timer expired |
| tmo_starver | input | 1 | A locked starving requester exists |
| hit | output | 1 | Request serviced this cycle |
| wr_req | output | 1 | Write-permission request issued |
| rd_req | output | 1 | Read request issued |
| retry | output | 1 | Request not serviced, to be re-queued |
| starve | output | 1 | Expiry handed to starver handling |
| line_state | output | 4 | Current line state code |
| trk_valid | output | 1 | Tracking entry allocated |
| trk_atomic | output | 1 | Tracking entry flagged atomic |

## Verification
The assertions assume that every input is 0 or 1 (never unknown) from the first clock after reset. Beyond that they allow any mix of events, including several in one cycle, because the priority rule determines the outcome. The random stimulus draws each field from `$urandom` with a fixed seed and makes most cycles carry a single event. About one cycle in eight carries colliding events, to exercise the priority and retry rule. Directed sequences drive the line through the atomic fill-and-expiry path with suppression on and off, and through the starver hold.

// File: rtl/l1_wperm_ctrl.sv
module l1_wperm_ctrl #(
  parameter int ST_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_no_mig,
  input  logic            req_valid,
  input  logic [1:0]      req_kind,
  input  logic            fill_valid,
  input  logic [1:0]      fill_kind,
  input  logic            inv_valid,
  input  logic            tmo_valid,
  input  logic            tmo_starver,
  output logic            hit,
  output logic            wr_req,
  output logic            rd_req,
  output logic            retry,
  output logic            starve,
  output logic [ST_W-1:0] line_state,
  output logic            trk_valid,
  output logic            trk_atomic
);

  localparam logic [ST_W-1:0] S_NP = 4'd0, S_I = 4'd1, S_S = 4'd2, S_O = 4'd3,
                              S_M = 4'd4, S_MM = 4'd5, S_MW = 4'd6, S_MMW = 4'd7,
                              S_IS = 4'd8, S_IM = 4'd9, S_SM = 4'd10, S_OM = 4'd11;

  logic [ST_W-1:0] st, st_nx;
  logic tv, ta, tv_nx, ta_nx;

  wire transient = (st == S_IS) || (st == S_IM) || (st == S_SM) || (st == S_OM);
  wire in_window = (st == S_MW) || (st == S_MMW);
  wire no_perm   = (st == S_NP) || (st == S_I);
  wire is_wr     = req_kind[1];
  wire is_at     = (req_kind == 2'd3);
  wire ev_at     = is_at && cfg_no_mig;
  wire req_go    = req_valid && !tmo_valid && !fill_valid && !inv_valid;
  wire wr_miss   = no_perm || (st == S_S) || (st == S_O);
  wire miss      = is_wr ? wr_miss : no_perm;

  assign retry  = req_valid && (!req_go || transient);
  assign hit    = req_go && !transient && !miss;
  assign wr_req = req_go && is_wr && wr_miss;
  assign rd_req = req_go && !is_wr && no_perm;
  assign starve = tmo_valid && tmo_starver && in_window;

  assign line_state = st;
  assign trk_valid  = tv;
  assign trk_atomic = ta;

  always_comb begin
    st_nx = st;
    tv_nx = tv;
    ta_nx = ta;
    if (tmo_valid) begin
      if (in_window && !tmo_starver) begin
        tv_nx = 1'b0;
        ta_nx = 1'b0;
        if (st == S_MW) st_nx = S_M;
        else st_nx = (cfg_no_mig && ta) ? S_M : S_MM;
      end
    end else if (fill_valid) begin
      if (st == S_IS) begin
        if (fill_kind[1]) st_nx = S_MW;
        else begin
          st_nx = fill_kind[0] ? S_O : S_S;
          tv_nx = 1'b0;
          ta_nx = 1'b0;
        end
      end else if (transient) begin
        st_nx = S_MMW;
      end
    end else if (inv_valid) begin
      if ((st == S_S) || (st == S_O) || (st == S_M) || (st == S_MM)) st_nx = S_I;
    end else if (req_valid && !transient) begin
      if (is_wr) begin
        if (wr_miss) begin
          tv_nx = 1'b1;
          ta_nx = is_at;
          case (st)
            S_S:     st_nx = S_SM;
            S_O:     st_nx = S_OM;
            default: st_nx = S_IM;
          endcase
        end else begin
          case (st)
            S_MM:    st_nx = ev_at ? S_M : S_MM;
            S_M:     st_nx = ev_at ? S_M : S_MM;
            S_MW:    st_nx = ev_at ? S_MW : S_MMW;
            default: st_nx = st;
          endcase
        end
      end else if (no_perm) begin
        st_nx = S_IS;
        tv_nx = 1'b1;
        ta_nx = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_NP;
      tv <= 1'b0;
      ta <= 1'b0;
    end else begin
      st <= st_nx;
      tv <= tv_nx;
      ta <= ta_nx;
    end
  end

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit, wr_req, rd_req, retry})); // R12
  AST_WR_TO_TRANSIENT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> (((line_state == S_IM) || (line_state == S_SM) || (line_state == S_OM)) && trk_valid)); // R3
  AST_RETRY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !tmo_valid && !fill_valid && !inv_valid && transient) |=> $stable(line_state)); // R5
  AST_ATOMIC_NOMIG: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cfg_no_mig && req_kind == 2'd3 && line_state == S_MM) |=> (line_state == S_M)); // R6
  AST_EXPIRY_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_valid && !tmo_starver && in_window) |=> !trk_valid); // R9
  AST_STARVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    starve |=> ($stable(line_state) && $stable(trk_valid))); // R10
  AST_NO_HIT_TRANSIENT: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> !transient); // R8

endmodule

// File: tb/tb_l1_wperm_ctrl.sv
module tb_l1_wperm_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, cfg = 0, rv = 0, fv = 0, iv = 0, tv_i = 0, ts = 0;
  logic [1:0] rk = 0, fk = 0;
  logic hit, wr_req, rd_req, retry, starve, trk_valid, trk_atomic;
  logic [3:0] line_state;

  int n_checks = 0, n_fail = 0;
  logic [3:0] m_st = 0;
  logic m_tv = 0, m_ta = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  l1_wperm_ctrl dut (.clk(clk), .rst_n(rst_n), .cfg_no_mig(cfg), .req_valid(rv), .req_kind(rk),
    .fill_valid(fv), .fill_kind(fk), .inv_valid(iv), .tmo_valid(tv_i), .tmo_starver(ts),
    .hit(hit), .wr_req(wr_req), .rd_req(rd_req), .retry(retry), .starve(starve),
    .line_state(line_state), .trk_valid(trk_valid), .trk_atomic(trk_atomic));

  task automatic check(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit trans(logic [3:0] s);
    return s >= 4'd8 && s <= 4'd11;
  endfunction

  task automatic step(logic c, logic r, logic [1:0] k, logic f, logic [1:0] fkk,
                      logic i, logic t, logic tsv);
    logic [4:0] e_out;
    logic [3:0] n_st;
    logic n_tv, n_ta, win, np, w_miss, go;
    string tag;
    cfg = c; rv = r; rk = k; fv = f; fk = fkk; iv = i; tv_i = t; ts = tsv;
    n_st = m_st; n_tv = m_tv; n_ta = m_ta; e_out = '0;
    win = (m_st == 4'd6) || (m_st == 4'd7);
    np = (m_st <= 4'd1);
    w_miss = m_st <= 4'd3;
    go = r && !t && !f && !i;
    tag = "R8";
    if (t) begin
      if (win) begin
        if (tsv) begin e_out[0] = 1; tag = "R10"; end
        else begin
          tag = "R9"; n_tv = 0; n_ta = 0;
          n_st = (m_st == 4'd6) ? 4'd4 : ((c && m_ta) ? 4'd4 : 4'd5);
        end
      end else tag = "R11";
    end else if (f) begin
      tag = "R4";
      if (m_st == 4'd8) begin
        if (fkk[1]) n_st = 4'd6;
        else begin n_st = fkk[0] ? 4'd3 : 4'd2; n_tv = 0; n_ta = 0; end
      end else if (trans(m_st)) n_st = 4'd7;
    end else if (i) begin
      tag = "R11";
      if (m_st >= 4'd2 && m_st <= 4'd5) n_st = 4'd1;
    end else if (r) begin
      if (trans(m_st)) begin tag = "R5"; e_out[1] = 1; end
      else if (k[1]) begin
        if (w_miss) begin
          tag = "R3"; e_out[3] = 1; n_tv = 1; n_ta = (k == 2'd3);
          n_st = (m_st == 4'd2) ? 4'd10 : (m_st == 4'd3) ? 4'd11 : 4'd9;
        end else begin
          e_out[4] = 1;
          tag = (k == 2'd3 && !c) ? "R2" : (m_st == 4'd5) ? "R6" : "R7";
          if (m_st == 4'd5 || m_st == 4'd4) n_st = (k == 2'd3 && c) ? 4'd4 : 4'd5;
          else if (m_st == 4'd6) n_st = (k == 2'd3 && c) ? 4'd6 : 4'd7;
        end
      end else begin
        if (np) begin tag = "R4"; e_out[2] = 1; n_st = 4'd8; n_tv = 1; n_ta = 0; end
        else begin tag = "R8"; e_out[4] = 1; end
      end
    end
    if (r && !go) begin e_out[1] = 1; tag = "R12"; end
    if ((int'(r) + int'(f) + int'(i) + int'(t)) > 1) tag = "R12";
    #1;
    check(tag, "pulses{hit,wr,rd,retry,starve}", {hit, wr_req, rd_req, retry, starve}, e_out);
    @(posedge clk);
    m_st = n_st; m_tv = n_tv; m_ta = n_ta;
    @(negedge clk);
    check(tag, "line_state", line_state, m_st);
    check(tag, "trk_valid", trk_valid, m_tv);
    check(tag, "trk_atomic", trk_atomic, m_ta);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    int unsigned seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R1", "state after reset", line_state, 0);
    check("R1", "trk after reset", {trk_valid, trk_atomic}, 0);
    check("R1", "pulses idle", {hit, wr_req, rd_req, retry, starve}, 0);
    @(negedge clk);
    // suppression on: atomic miss, fill, expiry resolves to M
    step(1, 1, 3, 0, 0, 0, 0, 0);
    step(1, 1, 2, 0, 0, 0, 0, 0);
    step(1, 0, 0, 1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 1, 1);
    step(1, 1, 2, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 1, 0);
    step(1, 1, 3, 0, 0, 0, 0, 0);
    step(1, 1, 2, 0, 0, 0, 0, 0);
    step(1, 1, 3, 0, 0, 0, 0, 0);
    // suppression off: atomic behaves like a store
    step(0, 0, 0, 0, 0, 1, 0, 0);
    step(0, 1, 3, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0);
    step(0, 1, 3, 0, 0, 0, 0, 0);
    // read miss, exclusive fill, atomic in M_W, expiry
    step(1, 0, 0, 0, 0, 1, 0, 0);
    step(1, 1, 1, 0, 0, 0, 0, 0);
    step(1, 0, 0, 1, 2, 0, 0, 0);
    step(1, 1, 3, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 1, 0);
    step(1, 0, 0, 0, 0, 0, 1, 0);
    // collisions
    step(1, 1, 2, 0, 0, 1, 0, 0);
    step(1, 1, 0, 1, 1, 0, 1, 0);
    for (int n = 0; n < 4000; n++) begin
      int unsigned sel = $urandom_range(0, 15);
      logic c = ($urandom_range(0, 3) != 0);
      logic r = 0, f = 0, i = 0, t = 0;
      if (sel < 7) r = 1;
      else if (sel < 10) f = 1;
      else if (sel < 12) i = 1;
      else if (sel < 14) t = 1;
      else begin r = 1; f = $urandom_range(0, 1); i = $urandom_range(0, 1); t = !f && !i; end
      step(c, r, 2'($urandom_range(0, 3)), f, 2'($urandom_range(0, 3)), i, t,
           1'($urandom_range(0, 2) == 0));
    end
    rv = 0; fv = 0; iv = 0; tv_i = 0;
    finish_run();
  end
endmodule